// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt request lines for a small signal-processing core and hands the core one request at a time, together with the fixed entry address of its handler. Each line is either captured on its rising edge into a pending latch or passed straight through as a level. A software mask register gates the lines, and one line is exempt from that mask. A global enable gates everything, that line included. Among the lines that survive, the one with the lowest index wins.

The core acknowledges the presented request, which marks that line as in service and clears its latched request. It later reports the end of the handler with a done strobe, which retires the highest-priority line still in service. A control register picks edge or level capture for three of the external lines and switches nesting on or off. A write-only force/clear register lets software raise or drop latched requests directly. For one cycle after every mask write, no request is presented.

Top module: `prio_vec_intc`

## Requirements
- R1: Line index sets priority, with index 0 highest. The handler address presented on `int_vec` is 0x0000 for line 0, 0x002C for line 1, and 4*(index-1) for lines 2 to 11, so line 11 gives 0x0028. `int_vec` reads 0 while `int_req` is low.
- R2: A line competes only when its mask bit (bit i of the mask register) is 1. Line 1 competes whatever its mask bit holds.
- R3: In the cycle that follows a cycle with `mask_we` high, `int_req` is low. The new mask applies from the cycle after that.
- R4: An edge-mode line records a pending request on a 0-to-1 change of its input. That request stays pending after the input falls, until it is acknowledged or cleared.
- R5: Lines 3 and 4 are always level-mode. Lines 2, 9 and 10 are level-mode when their control bit is 0. A level-mode line requests only while its input is high, and nothing is stored for it.
- R6: Control register bit 0 selects edge mode (1) for line 2, bit 1 does the same for line 9 and bit 2 for line 10. Bit 3 enables nesting. The register resets to 0, and the mask register resets to 0.
- R7: Bit i of `force_bits` sets the pending latch of edge-mode line i, and bit i of `clear_bits` clears it. When both are set, clear wins. Forcing a level-mode line has no effect.
- R8: A pulse on `dis_strobe` stops all requests, line 1 included, from the next cycle on. A pulse on `ena_strobe` resumes them. Requests are enabled after reset, and disable wins when both strobes pulse together.
- R9: `core_ack` while `int_req` is high marks the presented line as in service and clears its pending latch.
- R10: With nesting off, no request is presented while any line is in service. `core_done` retires the highest-priority in-service line.
- R11: With nesting on, a request is presented only when its priority is strictly higher than the highest-priority line in service.
- R12: After reset, `int_req` is 0 and no line is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_raw | input | NSRC | Raw request lines, synchronous to clk |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NSRC | Mask write data, 1 = line enabled |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control write data (mode bits and nesting) |
| force_bits | input | NSRC | One-cycle force of pending latches |
| clear_bits | input | NSRC | One-cycle clear of pending latches |
| ena_strobe | input | 1 | Global enable pulse |
| dis_strobe | input | 1 | Global disable pulse |
| core_ack | input | 1 | Core accepts the presented request |
| core_done | input | 1 | Core finished the current handler |
| int_req | output | 1 | A request is presented |
| int_vec | output | VEC_W | Handler address of the presented request |

## Verification
The bench builds the block with its default twelve lines and a 14-bit address. At that size every fixed mode is in reach: the three selectable lines, the always-level pair and the unmaskable line. Every handler address in the table comes up, including the out-of-order one for line 1. With lines this close together in priority, both nesting policies can be driven through ordered acknowledge and done sequences, and the order in which the in-service set is retired can be checked.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned NSRC_DEF = 12;
  // Lines that are edge-latched regardless of the control register
  localparam logic [NSRC_DEF-1:0] FIXED_EDGE = 12'h9E3;
  // Line exempt from the mask
  localparam logic [NSRC_DEF-1:0] NO_MASK    = 12'h002;
  // Lines whose capture mode comes from control bits 0..2
  localparam int unsigned SEL_A = 2;
  localparam int unsigned SEL_B = 9;
  localparam int unsigned SEL_C = 10;
  localparam int unsigned NEST_BIT = 3;

  function automatic int unsigned line_addr(input int unsigned idx);
    if (idx == 0) return 0;
    else if (idx == 1) return 32'h2C;
    else return 4 * (idx - 1);
  endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] force_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] active_o
);
  logic [N-1:0] prev_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = raw_i & ~prev_q & edge_mode_i;
    pend_d = ((pend_q & ~ack_clr_i) | rise | (force_i & edge_mode_i))
             & ~clr_i & edge_mode_i;
    active_o = pend_q | (raw_i & ~edge_mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= raw_i;
      pend_q <= pend_d;
    end
  end

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_i,
  input  logic [N-1:0] grant_i,
  input  logic         done_i,
  input  logic         nest_i,
  output logic [N-1:0] allow_o
);
  logic [N-1:0] isv_q, isv_d, low_bit;

  always_comb begin
    low_bit = isv_q & (~isv_q + 1'b1);
    isv_d   = isv_q & ~(done_i ? low_bit : '0);
    if (ack_i) isv_d = isv_d | grant_i;
    if (isv_q == '0)  allow_o = '1;
    else if (nest_i)  allow_o = low_bit - 1'b1;
    else              allow_o = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv_q <= '0;
    else        isv_q <= isv_d;
  end

  // R10
  serial_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !nest_i && !done_i) |=> $onehot(isv_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = 12,
  parameter int unsigned VEC_W = 14
) (
  input  logic [N-1:0]     cand_i,
  output logic             req_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vec_o
);
  import prio_intc_pkg::*;

  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    req_o   = |cand_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        vec_o = VEC_W'(line_addr(i));
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int unsigned NSRC  = 12,
  parameter int unsigned VEC_W = 14,
  parameter int unsigned CTL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_raw,
  input  logic             mask_we,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [NSRC-1:0]  force_bits,
  input  logic [NSRC-1:0]  clear_bits,
  input  logic             ena_strobe,
  input  logic             dis_strobe,
  input  logic             core_ack,
  input  logic             core_done,
  output logic             int_req,
  output logic [VEC_W-1:0] int_vec
);
  import prio_intc_pkg::*;

  logic [NSRC-1:0]  mask_q, mask_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             gie_q, gie_d, blk_q, blk_d;
  logic [NSRC-1:0]  edge_mode, active, allow, cand, grant, ack_clr;
  logic             ack_ok;

  // next-state
  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    ctl_d  = ctl_we  ? ctl_wdata  : ctl_q;
    blk_d  = mask_we;
    gie_d  = gie_q;
    if (ena_strobe) gie_d = 1'b1;
    if (dis_strobe) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctl_q  <= '0;
      gie_q  <= 1'b1;
      blk_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ctl_q  <= ctl_d;
      gie_q  <= gie_d;
      blk_q  <= blk_d;
    end
  end

  always_comb begin
    edge_mode = NSRC'(FIXED_EDGE);
    edge_mode[SEL_A] = ctl_q[0];
    edge_mode[SEL_B] = ctl_q[1];
    edge_mode[SEL_C] = ctl_q[2];
    cand = active & (mask_q | NSRC'(NO_MASK)) & allow
           & {NSRC{gie_q & ~blk_q}};
    ack_ok  = core_ack & int_req;
    ack_clr = ack_ok ? grant : '0;
  end

  irq_src_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .raw_i(src_raw), .edge_mode_i(edge_mode),
    .force_i(force_bits), .clr_i(clear_bits), .ack_clr_i(ack_clr),
    .active_o(active)
  );

  irq_svc_track #(.N(NSRC)) u_track (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_ok), .grant_i(grant),
    .done_i(core_done), .nest_i(ctl_q[NEST_BIT]), .allow_o(allow)
  );

  irq_pick #(.N(NSRC), .VEC_W(VEC_W)) u_pick (
    .cand_i(cand), .req_o(int_req), .grant_o(grant), .vec_o(int_vec)
  );

  // R3
  mask_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> !int_req);

  // R8
  gdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_strobe |=> !int_req);
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] src_raw = '0, mask_wdata = '0, force_bits = '0, clear_bits = '0;
  logic [3:0]  ctl_wdata = '0;
  logic mask_we = 0, ctl_we = 0, ena_strobe = 0, dis_strobe = 0;
  logic core_ack = 0, core_done = 0, int_req;
  logic [13:0] int_vec;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  prio_vec_intc u0 (.*);

  // {raw pattern, expected address}; request expected high
  localparam logic [25:0] TBL [8] = '{
    {12'h800, 14'h0028}, {12'h900, 14'h001C}, {12'h0A0, 14'h0010},
    {12'h008, 14'h0008}, {12'h003, 14'h0000}, {12'h006, 14'h002C},
    {12'h210, 14'h000C}, {12'h400, 14'h0024}};

  task automatic chk(input string tag, input logic [13:0] got, input logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask
  task automatic tick(); @(negedge clk); endtask
  task automatic wr_mask(input logic [11:0] v);
    mask_we = 1; mask_wdata = v; tick(); mask_we = 0;
  endtask
  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask
  task automatic frc(input logic [11:0] f, input logic [11:0] c);
    force_bits = f; clear_bits = c; tick(); force_bits = '0; clear_bits = '0;
  endtask
  task automatic ack(); core_ack = 1; tick(); core_ack = 0; endtask
  task automatic done(); core_done = 1; tick(); core_done = 0; endtask
  task automatic pulse_edge(input int i);
    src_raw[i] = 1'b1; tick(); src_raw[i] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R12 reset req", 14'(int_req), 14'h0);
    chk("R12 reset vec", int_vec, 14'h0);

    // R2 masked line held back; R3 one blocked cycle after mask write
    pulse_edge(11);
    chk("R2 masked", 14'(int_req), 14'h0);
    wr_mask(12'hFFF);
    chk("R3 blocked cycle", 14'(int_req), 14'h0);
    tick();
    chk("R3 after block req", 14'(int_req), 14'h1);
    chk("R2 unmasked vec", int_vec, 14'h0028);
    frc('0, 12'hFFF);

    // R2 unmaskable line 1
    wr_mask(12'h000); tick();
    pulse_edge(1);
    chk("R2 nomask req", 14'(int_req), 14'h1);
    chk("R2 nomask vec", int_vec, 14'h002C);
    frc('0, 12'hFFF);

    // table walk: R1 priorities and addresses, R4/R5 capture
    wr_mask(12'hFFF); wr_ctl(4'b0111); tick();
    for (int k = 0; k < 8; k++) begin
      src_raw = TBL[k][25:14];
      tick();
      chk("R1 table req", 14'(int_req), 14'h1);
      chk("R1 table vec", int_vec, TBL[k][13:0]);
      src_raw = '0;
      frc('0, 12'hFFF);
      chk("R1 table idle", 14'(int_req), 14'h0);
    end

    // R4 latched request survives input fall
    pulse_edge(7); tick();
    chk("R4 held vec", int_vec, 14'h0018);
    chk("R4 held req", 14'(int_req), 14'h1);
    frc('0, 12'hFFF);

    // R6/R5 line 2 in level mode follows its input
    wr_ctl(4'b0110);
    src_raw[2] = 1'b1; #1;
    chk("R5 level vec", int_vec, 14'h0004);
    src_raw[2] = 1'b0; #1;
    chk("R6 level not stored", 14'(int_req), 14'h0);
    tick(); chk("R5 level gone", 14'(int_req), 14'h0);
    wr_ctl(4'b0111);

    // R7 force, clear wins, level line ignores force
    frc(12'h100, '0);
    chk("R7 force vec", int_vec, 14'h001C);
    frc(12'h100, 12'h100);
    chk("R7 clear wins pend", 14'(int_req), 14'h0);
    frc(12'h040, 12'h040);
    chk("R7 clear wins new", 14'(int_req), 14'h0);
    frc(12'h008, '0);
    chk("R7 level force ignored", 14'(int_req), 14'h0);

    // R8 global disable incl. line 1
    dis_strobe = 1; tick(); dis_strobe = 0;
    frc(12'h002, '0);
    chk("R8 disabled", 14'(int_req), 14'h0);
    ena_strobe = 1; tick(); ena_strobe = 0;
    chk("R8 enabled vec", int_vec, 14'h002C);
    ena_strobe = 1; dis_strobe = 1; tick(); ena_strobe = 0; dis_strobe = 0;
    chk("R8 disable wins", 14'(int_req), 14'h0);
    ena_strobe = 1; tick(); ena_strobe = 0;
    frc('0, 12'hFFF);

    // R9/R10 nesting off
    frc(12'h800, '0);
    chk("R9 presented", int_vec, 14'h0028);
    ack();
    chk("R9 in service", 14'(int_req), 14'h0);
    frc(12'h100, '0);
    chk("R10 busy blocks", 14'(int_req), 14'h0);
    done();
    chk("R10 after done vec", int_vec, 14'h001C);
    ack(); done();
    chk("R9 ack cleared latch", 14'(int_req), 14'h0);

    // R11 nesting on
    wr_ctl(4'b1111);
    frc(12'h800, '0); ack();
    frc(12'h100, '0);
    chk("R11 higher nests", int_vec, 14'h001C);
    ack();
    frc(12'h200, '0);
    chk("R11 lower held", 14'(int_req), 14'h0);
    done();
    chk("R11 after pop vec", int_vec, 14'h0020);
    chk("R11 after pop req", 14'(int_req), 14'h1);
    ack(); done(); done();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule